// File: doc/BRIEF.md
# SIMD Lane Permutation Unit

This block reorders the elements of one or two packed operand vectors. It serves as the shuffle stage of a vector execution pipeline. On a start strobe the unit captures two 128-bit operands, a vector length (64 or 128 bits), an element width of 8, 16 or 32 bits, an operation code and a small immediate. One cycle later it presents two result vectors and a one-cycle done pulse. Two results are needed because interleave, de-interleave and transpose rewrite both registers of a pair. The other operations use only the first result and leave the second at zero.

The unit supports five shuffle families:
- a byte-granular extract from the concatenation of the two operands;
- element reversal inside 16-, 32- or 64-bit containers;
- a 2x2 transpose;
- interleave;
- de-interleave.

In 64-bit mode only the low halves of the operands take part, and the upper halves of both results are zero. A request that cannot be carried out raises an illegal flag and returns the first operand unchanged.

Top module: `vperm_unit`

## Requirements
- R1: With opCode 0 (extract), byte k of the first result is byte k+imm of the byte sequence formed by the active bytes of opA followed by the active bytes of opB. The active bytes are 8 in 64-bit mode and 16 in 128-bit mode. Extract ignores elemSize, and its second result is zero.
- R2: An extract in 64-bit mode with imm greater than 7 is illegal.
- R3: opCode 1, 2 and 3 reverse the order of elements of opA inside each 16-, 32- or 64-bit container, giving the first result. The second result is zero. elemSize 0, 1 and 2 select 8-, 16- and 32-bit elements.
- R4: A reversal whose element width is not smaller than its container, or whose elemSize is 3, is illegal.
- R5: opCode 5 (interleave) over n active elements: the first result holds A0,B0,A1,B1,… taken from elements 0..n/2-1. The second result holds the same pattern taken from elements n/2..n-1. Element 0 is the least significant.
- R6: opCode 6 (de-interleave): the first result holds the even-indexed elements of A and then the even-indexed elements of B. The second result holds the odd-indexed elements in the same order.
- R7: opCode 4 (transpose): for every even index i, the first result holds A[i],B[i] at positions i,i+1. The second result holds A[i+1],B[i+1] at the same positions.
- R8: elemSize 3 with opCode 4, 5 or 6 is illegal, and opCode 7 is always illegal. Any illegal request yields first result = active opA, second result = 0, and illegal = 1.
- R9: In 64-bit mode (wide = 0), operand bits 127:64 have no effect and result bits 127:64 are zero.
- R10: done is high exactly in the cycle after a cycle with start high. The results and illegal are registered and hold their values until the next start.
- R11: While reset is asserted, both results, done and illegal are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture request for this cycle's operands and controls |
| wide | input | 1 | 1 = 128-bit vectors, 0 = 64-bit vectors |
| elemSize | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| opCode | input | 3 | 0 extract, 1 rev16, 2 rev32, 3 rev64, 4 transpose, 5 interleave, 6 de-interleave, 7 reserved |
| imm | input | 4 | Extract byte offset |
| opA | input | 128 | First operand |
| opB | input | 128 | Second operand |
| outFirst | output | 128 | First result vector |
| outSecond | output | 128 | Second result vector |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last captured request was illegal |

## Verification
The bench sweeps every opcode, element width and vector length, and every extract offset, over several operand patterns whose upper halves are non-zero. A design that read the upper operand half in 64-bit mode, or that took interleave halves from the 128-bit midpoint, would therefore show wrong lanes. Extract offsets 0 and 15 and 64-bit offsets 8 to 15 catch an off-by-one shift direction or a missing range check. Reversals with the element width equal to the container catch a design that silently returns a partial reverse instead of flagging it. A changed operand after start exposes outputs that are not held.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  typedef enum logic [2:0] {
    OP_EXT   = 3'd0,
    OP_REV16 = 3'd1,
    OP_REV32 = 3'd2,
    OP_REV64 = 3'd3,
    OP_TRN   = 3'd4,
    OP_ZIP   = 3'd5,
    OP_UZP   = 3'd6,
    OP_RSVD  = 3'd7
  } permOp_e;

  typedef struct packed {
    logic capture;
    logic legal;
  } permCtl_t;
endpackage

// File: rtl/vperm_ctrl.sv
module vperm_ctrl
  import vperm_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int IMM_W = $clog2(VEC_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wide,
  input  logic [1:0]       elemSize,
  input  logic [2:0]       opCode,
  input  logic [IMM_W-1:0] imm,
  output permCtl_t         ctl,
  output logic             done,
  output logic             illegal
);
  logic legalReq;

  always_comb begin
    case (permOp_e'(opCode))
      OP_EXT:                 legalReq = wide || !imm[IMM_W-1];
      OP_REV16:               legalReq = (elemSize < 2'd1);
      OP_REV32:               legalReq = (elemSize < 2'd2);
      OP_REV64:               legalReq = (elemSize < 2'd3);
      OP_TRN, OP_ZIP, OP_UZP: legalReq = (elemSize != 2'd3);
      default:                legalReq = 1'b0;
    endcase
  end

  assign ctl.capture = start;
  assign ctl.legal   = legalReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= start;
      if (start) illegal <= !legalReq;
    end
  end
endmodule

// File: rtl/vperm_dp.sv
module vperm_dp
  import vperm_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int IMM_W = $clog2(VEC_W / 8),
  localparam int HALF_W = VEC_W / 2,
  localparam int NSIZES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  permCtl_t         ctl,
  input  logic             wide,
  input  logic [1:0]       elemSize,
  input  logic [2:0]       opCode,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] outFirst,
  output logic [VEC_W-1:0] outSecond
);
  logic [VEC_W-1:0]   amIn, bmIn, extRes, selF, selS;
  logic [2*VEC_W-1:0] catV, catSh;

  assign amIn = wide ? opA : {{HALF_W{1'b0}}, opA[HALF_W-1:0]};
  assign bmIn = wide ? opB : {{HALF_W{1'b0}}, opB[HALF_W-1:0]};

  // extract: one right shift of the operand pair, concatenated at the active length
  assign catV   = wide ? {opB, opA}
                       : {{VEC_W{1'b0}}, opB[HALF_W-1:0], opA[HALF_W-1:0]};
  assign catSh  = catV >> {imm, 3'b000};
  assign extRes = wide ? catSh[VEC_W-1:0] : {{HALF_W{1'b0}}, catSh[HALF_W-1:0]};

  for (genvar g = 0; g < NSIZES; g++) begin : sz
    localparam int E = 8 << g;
    localparam int NMAX = VEC_W / E;
    int halfN;
    logic [VEC_W-1:0] zipF, zipS, uzpF, uzpS, trnF, trnS, resF, resS;
    logic [VEC_W-1:0] revV [NSIZES];

    assign halfN = wide ? NMAX / 2 : NMAX / 4;

    always_comb begin
      zipF = '0; zipS = '0; uzpF = '0; uzpS = '0; trnF = '0; trnS = '0;
      for (int i = 0; i < NMAX / 2; i++) begin
        if (i < halfN) begin
          zipF[(2*i)*E +: E]     = amIn[i*E +: E];
          zipF[(2*i+1)*E +: E]   = bmIn[i*E +: E];
          zipS[(2*i)*E +: E]     = amIn[(halfN+i)*E +: E];
          zipS[(2*i+1)*E +: E]   = bmIn[(halfN+i)*E +: E];
          uzpF[i*E +: E]         = amIn[(2*i)*E +: E];
          uzpF[(halfN+i)*E +: E] = bmIn[(2*i)*E +: E];
          uzpS[i*E +: E]         = amIn[(2*i+1)*E +: E];
          uzpS[(halfN+i)*E +: E] = bmIn[(2*i+1)*E +: E];
          trnF[(2*i)*E +: E]     = amIn[(2*i)*E +: E];
          trnF[(2*i+1)*E +: E]   = bmIn[(2*i)*E +: E];
          trnS[(2*i)*E +: E]     = amIn[(2*i+1)*E +: E];
          trnS[(2*i+1)*E +: E]   = bmIn[(2*i+1)*E +: E];
        end
      end
    end

    always_comb begin : revBlk
      int per;
      for (int c = 0; c < NSIZES; c++) begin
        per = ((16 << c) > E) ? (16 << c) / E : 1;
        revV[c] = amIn;
        for (int k = 0; k < NMAX; k++) begin
          revV[c][k*E +: E] = amIn[((k / per) * per + per - 1 - (k % per))*E +: E];
        end
      end
    end

    always_comb begin
      resS = '0;
      case (permOp_e'(opCode))
        OP_REV16: resF = revV[0];
        OP_REV32: resF = revV[1];
        OP_REV64: resF = revV[2];
        OP_TRN:   begin resF = trnF; resS = trnS; end
        OP_ZIP:   begin resF = zipF; resS = zipS; end
        OP_UZP:   begin resF = uzpF; resS = uzpS; end
        default:  resF = '0;
      endcase
    end
  end

  always_comb begin
    selF = '0;
    selS = '0;
    if (!ctl.legal) begin
      selF = amIn;
    end else if (permOp_e'(opCode) == OP_EXT) begin
      selF = extRes;
    end else begin
      case (elemSize)
        2'd0:    begin selF = sz[0].resF; selS = sz[0].resS; end
        2'd1:    begin selF = sz[1].resF; selS = sz[1].resS; end
        2'd2:    begin selF = sz[2].resF; selS = sz[2].resS; end
        default: begin selF = '0; selS = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outFirst  <= '0;
      outSecond <= '0;
    end else if (ctl.capture) begin
      outFirst  <= selF;
      outSecond <= selS;
    end
  end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int IMM_W = $clog2(VEC_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wide,
  input  logic [1:0]       elemSize,
  input  logic [2:0]       opCode,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] outFirst,
  output logic [VEC_W-1:0] outSecond,
  output logic             done,
  output logic             illegal
);
  permCtl_t ctl;

  vperm_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
    .elemSize(elemSize), .opCode(opCode), .imm(imm),
    .ctl(ctl), .done(done), .illegal(illegal)
  );

  vperm_dp #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wide(wide),
    .elemSize(elemSize), .opCode(opCode), .imm(imm),
    .opA(opA), .opB(opB), .outFirst(outFirst), .outSecond(outSecond)
  );
endmodule

// File: rtl/vperm_chk.sv
module vperm_chk
  import vperm_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int IMM_W = $clog2(VEC_W / 8),
  localparam int HALF_W = VEC_W / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wide,
  input logic [1:0]       elemSize,
  input logic [2:0]       opCode,
  input logic [IMM_W-1:0] imm,
  input logic [VEC_W-1:0] opA,
  input logic [VEC_W-1:0] opB,
  input logic [VEC_W-1:0] outFirst,
  input logic [VEC_W-1:0] outSecond,
  input logic             done,
  input logic             illegal
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(outFirst) && $stable(outSecond) && $stable(illegal)));

  // R9
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wide) |=> (outFirst[VEC_W-1:HALF_W] == '0 && outSecond[VEC_W-1:HALF_W] == '0));

  // R3
  rev_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (opCode == OP_REV16 || opCode == OP_REV32 || opCode == OP_REV64)) |=> (outSecond == '0));

  // R4
  rev_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wide && opCode == OP_REV16 && elemSize != 2'd0) |=> (illegal && outFirst == $past(opA)));

  // R1
  ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wide && opCode == OP_EXT && imm == '0) |=> (!illegal && outFirst == $past(opA)));

  // R8
  rsvd_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opCode == OP_RSVD) |=> (illegal && outSecond == '0));
endmodule

bind vperm_unit vperm_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .elemSize(elemSize),
  .opCode(opCode), .imm(imm), .opA(opA), .opB(opB), .outFirst(outFirst),
  .outSecond(outSecond), .done(done), .illegal(illegal)
);

// File: tb/sim_vperm_unit.sv
`timescale 1ns/1ps
module sim_vperm_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         wide = 1'b0;
  logic [1:0]   elemSize = '0;
  logic [2:0]   opCode = '0;
  logic [3:0]   imm = '0;
  logic [127:0] opA = '0, opB = '0;
  logic [127:0] outFirst, outSecond;
  logic         done, illegal;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vperm_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .elemSize(elemSize),
    .opCode(opCode), .imm(imm), .opA(opA), .opB(opB), .outFirst(outFirst),
    .outSecond(outSecond), .done(done), .illegal(illegal)
  );

  task automatic chkVec(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] getEl(logic [127:0] v, int k, int e);
    logic [127:0] t;
    t = v >> (k * e);
    return (e == 32) ? t[31:0] : (t[31:0] & ((32'd1 << e) - 32'd1));
  endfunction

  function automatic logic [127:0] putEl(logic [127:0] v, int k, int e, logic [31:0] x);
    return v | ({96'b0, x} << (k * e));
  endfunction

  function automatic void model(input int op, input int sz, input bit w, input int im,
                                input logic [127:0] a, input logic [127:0] b,
                                output logic [127:0] f, output logic [127:0] s,
                                output bit ill);
    int nb, e, n, per, src;
    logic [127:0] am, bm;
    nb = w ? 16 : 8;
    am = w ? a : {64'b0, a[63:0]};
    bm = w ? b : {64'b0, b[63:0]};
    f = '0;
    s = '0;
    if (op == 0)                ill = !w && im > 7;
    else if (op >= 1 && op <= 3) ill = (sz >= 3) || ((8 << sz) >= (8 << op));
    else if (op >= 4 && op <= 6) ill = (sz == 3);
    else                         ill = 1'b1;
    if (ill) begin
      f = am;
      return;
    end
    if (op == 0) begin
      for (int k = 0; k < nb; k++) begin
        src = k + im;
        f = putEl(f, k, 8, (src < nb) ? getEl(am, src, 8) : getEl(bm, src - nb, 8));
      end
      return;
    end
    e = 8 << sz;
    n = nb * 8 / e;
    for (int k = 0; k < n; k++) begin
      case (op)
        1, 2, 3: begin
          per = (16 << (op - 1)) / e;
          f = putEl(f, k, e, getEl(am, k ^ (per - 1), e));
        end
        4: begin
          f = putEl(f, k, e, (k % 2 == 0) ? getEl(am, k, e) : getEl(bm, k - 1, e));
          s = putEl(s, k, e, (k % 2 == 0) ? getEl(am, k + 1, e) : getEl(bm, k, e));
        end
        5: begin
          f = putEl(f, k, e, (k % 2 == 0) ? getEl(am, k / 2, e) : getEl(bm, k / 2, e));
          s = putEl(s, k, e, (k % 2 == 0) ? getEl(am, n / 2 + k / 2, e) : getEl(bm, n / 2 + k / 2, e));
        end
        default: begin
          f = putEl(f, k, e, (k < n / 2) ? getEl(am, 2 * k, e) : getEl(bm, 2 * (k - n / 2), e));
          s = putEl(s, k, e, (k < n / 2) ? getEl(am, 2 * k + 1, e) : getEl(bm, 2 * (k - n / 2) + 1, e));
        end
      endcase
    end
  endfunction

  function automatic string tagFor(int op, bit ill);
    if (ill) return (op == 0) ? "R2" : ((op <= 3) ? "R4" : "R8");
    case (op)
      0: return "R1";
      1, 2, 3: return "R3";
      4: return "R7";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [127:0] mkPat(int seed, int salt);
    logic [127:0] v;
    v = '0;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'((i * 37 + seed * 53 + salt) & 255);
    return v;
  endfunction

  task automatic runOp(int op, int sz, bit w, int im, logic [127:0] a, logic [127:0] b);
    logic [127:0] f, s;
    bit ill;
    string tg;
    model(op, sz, w, im, a, b, f, s, ill);
    tg = tagFor(op, ill);
    @(negedge clk);
    opCode = 3'(op); elemSize = 2'(sz); wide = w; imm = 4'(im);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opA = ~a; opB = ~b;
    chkVec({tg, " first"}, outFirst, f);
    chkVec({tg, " second"}, outSecond, s);
    chkBit({tg, " illegal"}, illegal, ill);
    chkBit("R10 done pulse", done, 1'b1);
    if (!w) chkVec("R9 upper halves", {outFirst[127:64], outSecond[127:64]}, '0);
    @(negedge clk);
    chkBit("R10 done low", done, 1'b0);
    chkVec("R10 hold first", outFirst, f);
    chkBit("R10 hold illegal", illegal, ill);
  endtask

  bit finished = 1'b0;

  initial begin
    opA = {128{1'b1}}; opB = {128{1'b1}}; start = 1'b1; opCode = 3'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkVec("R11 reset first", outFirst, '0);
    chkVec("R11 reset second", outSecond, '0);
    chkBit("R11 reset done", done, 1'b0);
    chkBit("R11 reset illegal", illegal, 1'b0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chkBit("R11 idle done", done, 1'b0);
    chkVec("R11 idle first", outFirst, '0);
    for (int seed = 0; seed < 4; seed++) begin
      for (int w = 0; w < 2; w++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int op = 1; op < 8; op++) runOp(op, sz, w[0], seed, mkPat(seed, 11), mkPat(seed + 7, 145));
          for (int im = 0; im < 16; im++) runOp(0, sz, w[0], im, mkPat(seed, 3), mkPat(seed + 2, 200));
        end
      end
    end
    runOp(5, 0, 1'b1, 0, {128{1'b1}}, '0);
    runOp(6, 2, 1'b0, 0, '0, {128{1'b1}});
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule